// File: doc/BRIEF.md
# Unlock-Guarded Nonvolatile Byte Store Controller

This block sits between a processor's register bus and a 64-byte nonvolatile data store. The store is modelled as a RAM whose writes take a fixed number of clock cycles. Software reaches the store only indirectly. It loads a byte pointer and a byte buffer, then acts through a command register. A fourth location takes key bytes and holds no storage.

A read is a single command and fills the byte buffer at the next clock edge. A write is guarded against stray code. The write starts only when the command that requests it also carries the write-enable bit, and only when the last two key bytes written since the previous command were 55h and then AAh. While the write is in flight, the command register shows a busy bit. When the write finishes, a sticky finished flag is raised and a one-cycle pulse is sent to the interrupt controller.

Top module: `nvstore_ctrl`

## Requirements
- R1: After reset the pointer, the buffer and all command bits read 00h, and `wr_done_irq` is low.
- R2: Register select 0 is the byte pointer. It keeps the low 6 bits of a write, and its upper bits read 0. Select 1 is the byte buffer, which reads back what was written.
- R3: Select 2 is the command register. A write to it with bit 0 set loads the buffer with the stored byte at the pointer, and the buffer is readable on the next cycle. Bit 0 always reads 0.
- R4: Select 3 is the key location. It always reads 00h, and writing it changes no readable register.
- R5: A write to the command register that has bits 1 (write enable) and 2 (start) both set starts a store write, but only when the key sequence is armed and no write is busy. With bit 1 clear, nothing starts. Every command write disarms the key sequence.
- R6: The key sequence is armed only by 55h followed directly by AAh at the key location. Any other key byte restarts the sequence, and a fresh 55h always counts as its first step.
- R7: Bit 2 reads 1 for exactly WR_LAT cycles after the start edge. Hardware clears it, and software writes cannot clear it.
- R8: At completion, the store holds the buffer value at the pointer address as both stood at the start edge. `wr_done_irq` is high for exactly one cycle.
- R9: Bit 4 (finished) is set by completion and stays set until a command write with bit 4 clear. Bit 1 reads back the last written enable value.
- R10: A complete key sequence and start command issued while a write is busy neither starts a second write nor produces a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | DW | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | DW | Combinational read data |
| wr_done_irq | output | 1 | One-cycle pulse when a store write finishes |

## Verification
The bench goes after the key-sequence corners: an intruding byte between 55h and AAh, a repeated 55h, AAh on its own, and a start command with the enable bit clear. A design that checked only the last byte, or only whether both bytes had ever arrived, would start writes that should be refused. The bench also counts busy cycles against WR_LAT and fires a full key sequence while a write is busy. An off-by-one counter, or a missing busy guard, would show up as a wrong busy length or as a second pulse. Random traffic then changes the pointer and the buffer during busy writes, so a design that failed to capture them at the start edge would store the wrong byte at the wrong place.

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl #(
  parameter int AW     = 6,
  parameter int DW     = 8,
  parameter int WR_LAT = 16,
  localparam int DEPTH = 1 << AW,
  localparam int CW    = $clog2(WR_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          wr_done_irq
);
  localparam logic [1:0] SEL_PTR = 2'd0, SEL_BUF = 2'd1, SEL_CMD = 2'd2, SEL_KEY = 2'd3;
  localparam int B_RD = 0, B_WEN = 1, B_GO = 2, B_FIN = 4;
  localparam logic [DW-1:0] KEY_A = DW'(8'h55);
  localparam logic [DW-1:0] KEY_B = DW'(8'hAA);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q, wptr_q;
  logic [DW-1:0] buf_q, wbuf_q;
  logic          wen_q, fin_q, busy_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    key_q;

  wire cmd_wr = wr_en && wr_sel == SEL_CMD;
  wire key_wr = wr_en && wr_sel == SEL_KEY;
  wire finish = busy_q && cnt_q == '0;
  wire start  = cmd_wr && !busy_q && wr_data[B_WEN] && wr_data[B_GO] && key_q == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      buf_q <= '0;
      wen_q <= 1'b0;
      fin_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q <= '0;
      key_q <= 2'd0;
      wptr_q <= '0;
      wbuf_q <= '0;
      wr_done_irq <= 1'b0;
    end else begin
      wr_done_irq <= finish;
      if (finish) busy_q <= 1'b0;
      else if (busy_q) cnt_q <= cnt_q - 1'b1;
      if (wr_en && wr_sel == SEL_PTR) ptr_q <= wr_data[AW-1:0];
      if (wr_en && wr_sel == SEL_BUF) buf_q <= wr_data;
      if (cmd_wr) begin
        wen_q <= wr_data[B_WEN];
        key_q <= 2'd0;
        if (wr_data[B_RD]) buf_q <= mem[ptr_q];
      end
      if (finish) fin_q <= 1'b1;
      else if (cmd_wr) fin_q <= fin_q & wr_data[B_FIN];
      if (start) begin
        busy_q <= 1'b1;
        cnt_q <= CW'(WR_LAT - 1);
        wptr_q <= ptr_q;
        wbuf_q <= buf_q;
      end
      if (key_wr) begin
        if (wr_data == KEY_A) key_q <= 2'd1;
        else if (key_q == 2'd1 && wr_data == KEY_B) key_q <= 2'd2;
        else key_q <= 2'd0;
      end
    end
  end

  always_ff @(posedge clk)
    if (finish) mem[wptr_q] <= wbuf_q;

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_PTR: rd_data[AW-1:0] = ptr_q;
      SEL_BUF: rd_data = buf_q;
      SEL_CMD: begin
        rd_data[B_WEN] = wen_q;
        rd_data[B_GO]  = busy_q;
        rd_data[B_FIN] = fin_q;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/nvstore_ctrl_chk.sv
module nvstore_ctrl_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cnt_zero,
  input logic          irq,
  input logic          fin,
  input logic          armed,
  input logic [1:0]    rd_sel,
  input logic [DW-1:0] rd_data
);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy && !cnt_zero |=> busy);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R8
  irq_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(busy) && !busy);
  // R9
  irq_sets_fin_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> fin);
  // R5
  start_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(armed));
  // R4
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_sel == 2'd3 |-> rd_data == '0);
  // R3
  rd_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_sel == 2'd2 |-> !rd_data[0]);
endmodule

bind nvstore_ctrl nvstore_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .cnt_zero(cnt_q == '0),
  .irq(wr_done_irq), .fin(fin_q), .armed(key_q == 2'd2),
  .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/nvstore_ctrl_tb.sv
`timescale 1ns/1ps
module nvstore_ctrl_tb_top;
  localparam int LAT = 5;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0, rd_data;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  nvstore_ctrl #(.AW(6), .DW(8), .WR_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .wr_done_irq(irq));

  logic [5:0] m_ptr, m_wptr;
  logic [7:0] m_buf, m_wbuf;
  logic [7:0] m_mem [64];
  logic m_wen, m_fin, m_busy, m_irq;
  int m_cnt, m_key;

  function automatic logic [7:0] exp_rd(input int s);
    case (s)
      0: return {2'b00, m_ptr};
      1: return m_buf;
      2: return {3'b000, m_fin, 1'b0, m_busy, m_wen, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic we, input logic [1:0] s, input logic [7:0] d);
    logic fin_now = m_busy && m_cnt == 0;
    logic busy_old = m_busy;
    logic [7:0] rdv = m_mem[m_ptr];
    logic [5:0] p_old = m_ptr;
    logic [7:0] b_old = m_buf;
    m_irq = fin_now;
    if (fin_now) begin m_mem[m_wptr] = m_wbuf; m_busy = 0; m_fin = 1; end
    else if (m_busy) m_cnt--;
    if (we) case (s)
      2'd0: m_ptr = d[5:0];
      2'd1: m_buf = d;
      2'd2: begin
        m_wen = d[1];
        if (d[0]) m_buf = rdv;
        if (!fin_now) m_fin = m_fin & d[4];
        if (!busy_old && d[1] && d[2] && m_key == 2) begin
          m_busy = 1; m_cnt = LAT - 1; m_wptr = p_old; m_wbuf = b_old;
        end
        m_key = 0;
      end
      default: m_key = (d == 8'h55) ? 1 : (m_key == 1 && d == 8'hAA) ? 2 : 0;
    endcase
  endtask

  task automatic read_reg(input int s, output logic [7:0] v);
    rd_sel = 2'(s); #0.5; v = rd_data;
  endtask

  task automatic step(input logic we, input logic [1:0] s, input logic [7:0] d, input string tag);
    logic [7:0] v;
    model_edge(we, s, d);
    wr_en = we; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      read_reg(i, v);
      chk(v === exp_rd(i), $sformatf("%s reg%0d", tag, i), v, exp_rd(i));
    end
    chk(irq === m_irq, {tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
  endtask

  task automatic keys(input logic [7:0] a, input logic [7:0] b, input string tag);
    step(1, 2'd3, a, tag); step(1, 2'd3, b, tag);
  endtask

  task automatic store(input logic [5:0] a, input logic [7:0] d, input string tag);
    step(1, 2'd0, {2'b0, a}, tag); step(1, 2'd1, d, tag);
    keys(8'h55, 8'hAA, tag); step(1, 2'd2, 8'h06, tag);
    for (int i = 0; i < LAT + 1; i++) step(0, 2'd0, 8'h00, tag);
  endtask

  initial begin
    logic [7:0] v;
    int busy_n, irq_n;
    void'($urandom(32'd2024));
    m_ptr = 0; m_buf = 0; m_wen = 0; m_fin = 0; m_busy = 0; m_irq = 0;
    m_cnt = 0; m_key = 0; m_wptr = 0; m_wbuf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      read_reg(i, v);
      chk(v === 8'h00, "R1 reset value", v, 8'h00);
    end
    chk(irq === 1'b0, "R1 irq low", {7'd0, irq}, 8'h00);

    for (int a = 0; a < 64; a++) store(6'(a), 8'(a * 37 + 11), "R8 preload");

    step(1, 2'd0, 8'hFF, "R2 pointer");
    read_reg(0, v); chk(v === 8'h3F, "R2 pointer width", v, 8'h3F);
    step(1, 2'd1, 8'h5A, "R2 buffer");
    read_reg(1, v); chk(v === 8'h5A, "R2 buffer readback", v, 8'h5A);
    step(1, 2'd2, 8'h01, "R3 read cmd");
    read_reg(1, v); chk(v === 8'(63 * 37 + 11), "R3 read fills buffer", v, 8'(63 * 37 + 11));

    step(1, 2'd3, 8'h77, "R4 key write");
    read_reg(3, v); chk(v === 8'h00, "R4 key reads zero", v, 8'h00);

    step(1, 2'd0, 8'h05, "R8"); step(1, 2'd1, 8'hA5, "R8");
    keys(8'h55, 8'hAA, "R6"); step(1, 2'd2, 8'h06, "R5 start");
    busy_n = 0; irq_n = 0;
    for (int i = 0; i < LAT + 3; i++) begin
      read_reg(2, v); if (v[2]) busy_n++;
      if (irq) irq_n++;
      step(1, 2'd2, 8'h12, "R7 software write during busy");
    end
    chk(busy_n == LAT, "R7 busy length", 8'(busy_n), 8'(LAT));
    chk(irq_n == 1, "R8 single pulse", 8'(irq_n), 8'd1);
    step(1, 2'd2, 8'h11, "R8 readback");
    read_reg(1, v); chk(v === 8'hA5, "R8 stored byte", v, 8'hA5);
    read_reg(2, v); chk(v[4] === 1'b1, "R9 finished sticky", v, 8'h10);
    step(1, 2'd2, 8'h00, "R9 clear");
    read_reg(2, v); chk(v[4] === 1'b0, "R9 finished cleared", v, 8'h00);

    step(1, 2'd1, 8'hC3, "R6");
    step(1, 2'd3, 8'h55, "R6"); step(1, 2'd3, 8'h12, "R6"); step(1, 2'd3, 8'hAA, "R6");
    step(1, 2'd2, 8'h06, "R6 intruder");
    read_reg(2, v); chk(v[2] === 1'b0, "R6 intruder refused", v, 8'h02);
    step(1, 2'd3, 8'hAA, "R6"); step(1, 2'd2, 8'h06, "R6 lone AA");
    read_reg(2, v); chk(v[2] === 1'b0, "R6 lone AA refused", v, 8'h02);
    keys(8'h55, 8'hAA, "R5"); step(1, 2'd2, 8'h04, "R5 no enable");
    read_reg(2, v); chk(v[2] === 1'b0, "R5 enable clear refused", v, 8'h00);
    step(1, 2'd3, 8'h55, "R6"); keys(8'h55, 8'hAA, "R6"); step(1, 2'd2, 8'h06, "R6 double 55");
    read_reg(2, v); chk(v[2] === 1'b1, "R6 repeated 55 accepted", v, 8'h06);
    irq_n = 0;
    keys(8'h55, 8'hAA, "R10"); step(1, 2'd2, 8'h06, "R10 retrigger");
    for (int i = 0; i < 3 * LAT; i++) begin
      if (irq) irq_n++;
      step(0, 2'd0, 8'h00, "R10 idle");
    end
    chk(irq_n == 1, "R10 one pulse only", 8'(irq_n), 8'd1);

    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      case (op)
        0: step(1, 2'd0, d, "rand R2 ptr");
        1: step(1, 2'd1, d, "rand R2 buf");
        2, 3: step(1, 2'd3, 8'h55, "rand R6");
        4, 5: step(1, 2'd3, 8'hAA, "rand R6");
        6: step(1, 2'd3, d, "rand R4");
        7, 8: step(1, 2'd2, ($urandom_range(0, 1) != 0) ? (d | 8'h06) : d, "rand R5 R3 R9");
        default: step(0, 2'd0, 8'h00, "rand R7 idle");
      endcase
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule